// File: doc/BRIEF.md
# Two-Toggle-Flop Mealy Sequence Circuit

This block is a tiny synchronous Mealy machine whose whole state lives in two toggle flip-flops, called A and B. On every rising clock edge each flop either keeps its value or inverts it, as chosen by its toggle input. Those toggle inputs, and the single output bit, are fixed logic functions of the present state and of two serial input bits, X1 and X2, sampled each cycle.

Each state bit has its own active-high asynchronous preset and clear line. These load a known state at once, with no clock edge needed, and are held low in normal running. The output is combinational, so it follows the inputs between clock edges. Both state bits are driven out so that the current state can be observed.

Top module: `tff_mealy_seq`

## Requirements
- R1: Driving clear high for a state bit (`clr_a_i` for A, `clr_b_i` for B) forces that bit to 0 at once, without waiting for a clock edge.
- R2: Driving preset high for a state bit (`pre_a_i` for A, `pre_b_i` for B) while its clear is low forces that bit to 1 at once, without waiting for a clock edge.
- R3: When preset and clear of the same bit are both high, clear wins and the bit reads 0.
- R4: On each rising clock edge with A's preset and clear low, A inverts when `x1_i & b` is 1 and keeps its value when it is 0.
- R5: On each rising clock edge with B's preset and clear low, B inverts when `x2_i | a` is 1 and keeps its value when it is 0.
- R6: `y_o` equals `x1_i & ~b` at all times, where b is the current value of state bit B. It changes as soon as `x1_i` changes, with no clock edge needed.
- R7: While a bit's preset or clear is held high, clock edges do not change that bit, whatever its toggle input.
- R8: `a_o` and `b_o` always show the current values of state bits A and B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; state updates on the rising edge |
| pre_a_i | input | 1 | Asynchronous active-high preset of bit A |
| clr_a_i | input | 1 | Asynchronous active-high clear of bit A (has priority) |
| pre_b_i | input | 1 | Asynchronous active-high preset of bit B |
| clr_b_i | input | 1 | Asynchronous active-high clear of bit B (has priority) |
| x1_i | input | 1 | First serial input bit |
| x2_i | input | 1 | Second serial input bit |
| y_o | output | 1 | Mealy output, X1 AND NOT B |
| a_o | output | 1 | Current value of state bit A |
| b_o | output | 1 | Current value of state bit B |

## Verification
The bench loads each of the four states through the preset and clear lines. From each one it applies all four input pairs and compares the output and the next state with a model of the equations. A swapped or inverted term in either toggle equation shows up as a wrong next state in at least one of the sixteen pairs. The bench also samples between clock edges: right after an asynchronous load, to catch a flop that waits for the clock, and right after X1 changes, to catch an output that was registered instead of combinational. Asserting preset and clear together catches a design that gives preset the priority, because the bit then reads 1. Holding clear across an edge while the toggle input is 1 catches a flop that lets the toggle through during a load.

// File: rtl/tff_mealy_pkg.sv
package tff_mealy_pkg;

    localparam int unsigned NUM_FF = 2;
    localparam int unsigned IDX_A  = 1;
    localparam int unsigned IDX_B  = 0;

    typedef struct packed {
        logic tog_a;
        logic tog_b;
        logic y;
    } eqn_out_t;

endpackage

// File: rtl/tff_cell.sv
module tff_cell (
    input  logic clk_i,
    input  logic pre_i,
    input  logic clr_i,
    input  logic tog_i,
    output logic q_o
);

    logic q_d;
    logic q_q;

    always_comb begin
        q_d = tog_i ? ~q_q : q_q;
    end

    always_ff @(posedge clk_i or posedge clr_i or posedge pre_i) begin
        if (clr_i) begin
            q_q <= 1'b0;
        end else if (pre_i) begin
            q_q <= 1'b1;
        end else begin
            q_q <= q_d;
        end
    end

    assign q_o = q_q;

    AST_CLR_FORCES_ZERO: assert property (@(posedge clk_i)
        clr_i |-> (q_o == 1'b0)); // R3

    AST_PRE_FORCES_ONE: assert property (@(posedge clk_i)
        (pre_i && !clr_i) |-> (q_o == 1'b1)); // R2

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (pre_i || clr_i)
        !tog_i |=> $stable(q_o)); // R7

endmodule

// File: rtl/tff_mealy_eqn.sv
module tff_mealy_eqn
    import tff_mealy_pkg::*;
(
    input  logic     a_i,
    input  logic     b_i,
    input  logic     x1_i,
    input  logic     x2_i,
    output eqn_out_t eq_o
);

    eqn_out_t eq_d;

    always_comb begin
        eq_d       = '0;
        eq_d.tog_a = x1_i & b_i;
        eq_d.tog_b = x2_i | a_i;
        eq_d.y     = x1_i & ~b_i;
    end

    assign eq_o = eq_d;

endmodule

// File: rtl/tff_mealy_seq.sv
module tff_mealy_seq
    import tff_mealy_pkg::*;
(
    input  logic clk_i,
    input  logic pre_a_i,
    input  logic clr_a_i,
    input  logic pre_b_i,
    input  logic clr_b_i,
    input  logic x1_i,
    input  logic x2_i,
    output logic y_o,
    output logic a_o,
    output logic b_o
);

    logic [NUM_FF-1:0] pre_vec;
    logic [NUM_FF-1:0] clr_vec;
    logic [NUM_FF-1:0] tog_vec;
    logic [NUM_FF-1:0] st_q;
    eqn_out_t          eq;

    always_comb begin
        pre_vec        = '0;
        clr_vec        = '0;
        tog_vec        = '0;
        pre_vec[IDX_A] = pre_a_i;
        pre_vec[IDX_B] = pre_b_i;
        clr_vec[IDX_A] = clr_a_i;
        clr_vec[IDX_B] = clr_b_i;
        tog_vec[IDX_A] = eq.tog_a;
        tog_vec[IDX_B] = eq.tog_b;
    end

    tff_mealy_eqn u_eqn (
        .a_i  (st_q[IDX_A]),
        .b_i  (st_q[IDX_B]),
        .x1_i (x1_i),
        .x2_i (x2_i),
        .eq_o (eq)
    );

    for (genvar g = 0; g < NUM_FF; g++) begin : g_ff
        tff_cell u_cell (
            .clk_i (clk_i),
            .pre_i (pre_vec[g]),
            .clr_i (clr_vec[g]),
            .tog_i (tog_vec[g]),
            .q_o   (st_q[g])
        );
    end

    assign a_o = st_q[IDX_A];
    assign b_o = st_q[IDX_B];
    assign y_o = eq.y;

    AST_A_TOGGLES_ON_X1_B: assert property (@(posedge clk_i) disable iff (pre_a_i || clr_a_i)
        (x1_i && b_o) |=> (a_o != $past(a_o))); // R4

    AST_A_HOLDS_OTHERWISE: assert property (@(posedge clk_i) disable iff (pre_a_i || clr_a_i)
        !(x1_i && b_o) |=> (a_o == $past(a_o))); // R4

    AST_B_TOGGLES_ON_X2_A: assert property (@(posedge clk_i) disable iff (pre_b_i || clr_b_i)
        (x2_i || a_o) |=> (b_o != $past(b_o))); // R5

    AST_B_HOLDS_OTHERWISE: assert property (@(posedge clk_i) disable iff (pre_b_i || clr_b_i)
        !(x2_i || a_o) |=> (b_o == $past(b_o))); // R5

    AST_Y_LOW_WHEN_B_SET: assert property (@(posedge clk_i) disable iff (clr_b_i)
        b_o |-> !y_o); // R6

endmodule

// File: tb/tb_tff_mealy_seq.sv
module tb_tff_mealy_seq;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic pre_a = 1'b0, clr_a = 1'b1, pre_b = 1'b0, clr_b = 1'b1;
    logic x1 = 1'b0, x2 = 1'b0;
    logic y, a, b;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tff_mealy_seq dut (
        .clk_i   (clk),
        .pre_a_i (pre_a),
        .clr_a_i (clr_a),
        .pre_b_i (pre_b),
        .clr_b_i (clr_b),
        .x1_i    (x1),
        .x2_i    (x2),
        .y_o     (y),
        .a_o     (a),
        .b_o     (b)
    );

    task automatic check(input string req, input string what,
                         input logic [2:0] act, input logic [2:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic load_state(input logic sa, input logic sb);
        @(negedge clk);
        pre_a = sa; clr_a = ~sa;
        pre_b = sb; clr_b = ~sb;
        @(negedge clk);
        pre_a = 0; clr_a = 0; pre_b = 0; clr_b = 0;
        #1;
    endtask

    task automatic t_reset_state();
        #1;
        check("R1", "state after clear at start", {1'b0, a, b}, 3'b000);
        check("R8", "y after clear, x1=0", {2'b00, y}, 3'b000);
    endtask

    task automatic t_async_load();
        load_state(1'b0, 1'b0);
        #2;
        pre_a = 1; pre_b = 1;
        #1;
        check("R2", "preset without clock edge", {1'b0, a, b}, 3'b011);
        pre_a = 0; pre_b = 0;
        #1;
        clr_b = 1;
        #1;
        check("R1", "clear B without clock edge", {1'b0, a, b}, 3'b010);
        clr_b = 0;
    endtask

    task automatic t_clear_priority();
        @(negedge clk);
        #1;
        pre_a = 1; clr_a = 1; pre_b = 1; clr_b = 1;
        #1;
        check("R3", "clear wins over preset", {1'b0, a, b}, 3'b000);
        @(negedge clk);
        check("R3", "clear still wins after edge", {1'b0, a, b}, 3'b000);
        pre_a = 0; clr_a = 0; pre_b = 0; clr_b = 0;
    endtask

    task automatic t_hold_during_load();
        load_state(1'b0, 1'b1);
        clr_a = 1; x1 = 1; x2 = 0;
        @(negedge clk);
        check("R7", "A held by clear across edge with TA=1", {2'b00, a}, 3'b000);
        check("R5", "B toggles with X2=0 since A=0? no: holds", {2'b00, b}, 3'b001);
        clr_a = 0; x1 = 0;
    endtask

    task automatic t_all_pairs();
        for (int s = 0; s < 4; s++) begin
            for (int inp = 0; inp < 4; inp++) begin
                logic sa, sb, i1, i2, na, nb, ey;
                sa = s[1]; sb = s[0]; i1 = inp[1]; i2 = inp[0];
                load_state(sa, sb);
                check("R8", "loaded state", {1'b0, a, b}, {1'b0, sa, sb});
                x1 = i1; x2 = i2;
                #1;
                ey = i1 & ~sb;
                check("R6", "mealy output before edge", {2'b00, y}, {2'b00, ey});
                na = sa ^ (i1 & sb);
                nb = sb ^ (i2 | sa);
                @(negedge clk);
                check("R4", "next A", {2'b00, a}, {2'b00, na});
                check("R5", "next B", {2'b00, b}, {2'b00, nb});
                x1 = 0; x2 = 0;
            end
        end
    endtask

    task automatic t_mealy_comb();
        load_state(1'b0, 1'b0);
        x2 = 0; x1 = 0;
        #1;
        check("R6", "y with x1=0,b=0", {2'b00, y}, 3'b000);
        x1 = 1;
        #1;
        check("R6", "y follows x1 rise mid-cycle", {2'b00, y}, 3'b001);
        x1 = 0;
        #1;
        check("R6", "y follows x1 fall mid-cycle", {2'b00, y}, 3'b000);
        load_state(1'b1, 1'b1);
        x1 = 1;
        #1;
        check("R6", "y low when b=1", {2'b00, y}, 3'b000);
        x1 = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        @(negedge clk);
        clr_a = 0; clr_b = 0;
        t_async_load();
        t_clear_priority();
        t_hold_during_load();
        t_all_pairs();
        t_mealy_comb();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule